// File: doc/BRIEF.md
# Burst-of-Four Double-Data-Rate SRAM Core

This block is a small synchronous static memory with a double-data-rate interface. It has one address bus, a separate write-data bus and a separate read-data bus. Every access moves a fixed group of four words. The words cross the interface on alternating half-periods of the interface clock. The design runs from one clock `clk` at twice the interface rate. An internal phase bit divides the edges of `clk` into "K" edges (the rising edge of the interface clock) and "K#" edges (its falling edge). The phase bit is brought out as `k_edge_o` so that the surrounding logic knows which edge comes next.

Commands are sampled only on K edges. The read and write strobes are active low. A read returns its four words starting on the third `clk` edge after the command. A write takes its data late: the first word arrives two edges after the command, and the other three follow on the next three edges. Each word of a write has active-low byte-lane enables that are sampled with it. The echo output `echo_o` alternates with the same registered timing as the read data, so a receiver can use it as a capture strobe.

The array holds `2**AW` bursts of four `DW`-bit words. A read works from a copy of its burst taken at the command edge. Reads and writes may therefore target the same burst while their bursts overlap, with a defined result.

Top module: `qdr_burst_sram`

## Requirements
- R1: Each access moves exactly four words. `addr` selects a burst. The words of a burst go to, and come back from, word offsets 0, 1, 2 and 3 in that order.
- R2: A read is accepted when `rd_n` is low at a K edge, which is an edge where `k_edge_o` was high just before it. If the command edge is edge e, word i is on `q` with `q_vld` high after edge e+3+i. `q_vld` is low whenever no accepted read is delivering. Reads accepted every second K edge give gapless data.
- R3: Holding `rd_n` high while a burst is in flight does not shorten it. `rd_n` and `wr_n` are ignored on K# edges.
- R4: A low `rd_n` on the K edge directly after an accepted read is ignored and produces no data.
- R5: A write is accepted when `wr_n` is low at K edge e, with `addr` sampled on that same edge. Word i is taken from `d` at edge e+2+i. Data on `d` at any other edge is not stored.
- R6: A low `wr_n` on the K edge directly after an accepted write is ignored. Its address is not written, and the following data edges still belong to the first write.
- R7: `bw_n[j]` low lets lane j (bits 9j+8 down to 9j) of the current write word be stored. A high bit keeps that lane's old content. The enables are sampled with each word.
- R8: A read returns the burst as it stood before its command edge. Write words taken on the command edge or later do not appear in that read, even when a read and a write to the same burst are accepted on the same K edge.
- R9: `echo_o` is high after a K# edge and low after a K edge, registered in step with `q`. Word 0 of every read is therefore delivered with `echo_o` high.
- R10: `k_edge_o` is high during reset and after it, so the first edge after reset is a K edge. It then alternates on every edge.
- R11: Synchronous reset (`rst` high) clears `q` to 0 and `q_vld` to 0 and drops any accepted read or write that has not finished.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Double-rate clock; every rising edge is a K or K# edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_n | input | 1 | Active-low read strobe, sampled on K edges |
| wr_n | input | 1 | Active-low write strobe, sampled on K edges |
| addr | input | AW | Burst address for read and write commands |
| d | input | DW | Write data, one word per edge during the data window |
| bw_n | input | DW/9 | Active-low byte-lane enables for the current write word |
| q | output | DW | Read data, one word per edge |
| q_vld | output | 1 | High while `q` holds a read word |
| echo_o | output | 1 | Echo strobe, high after K# edges |
| k_edge_o | output | 1 | High when the next edge is a K edge |

## Verification
Read word i is due exactly 3+i edges after its command edge. Write word i is taken exactly 2+i edges after its command edge. The bench counts edges from the release of reset and files each expected read word in a schedule slot keyed by the edge it is due on. After every edge it compares `q`, `q_vld` and `echo_o` against that slot, half a period away from the active edge, and requires `q_vld` low when the slot is empty. Data that must not be stored is driven with all lanes enabled on the edges just outside the write window and after ignored strobes. Read-backs then show whether any such word reached the array.

// File: rtl/qdr_pkg.sv
package qdr_pkg;

    // Words moved per access and width of one byte lane
    parameter int unsigned BURST_LEN = 4;
    parameter int unsigned LANE_W    = 9;

    localparam int unsigned WIDX_W = $clog2(BURST_LEN);

    typedef logic [WIDX_W-1:0] widx_t;

    // Which edge of the double-rate clock comes next
    typedef enum logic {
        PH_KB = 1'b0,
        PH_K  = 1'b1
    } phase_e;

    // Progress of a burst through its four word slots
    typedef struct packed {
        logic  on;
        widx_t nxt;
    } seq_t;

    function automatic logic is_last_word(input widx_t idx);
        return idx == widx_t'(BURST_LEN - 1);
    endfunction

    function automatic seq_t seq_advance(input seq_t s);
        seq_t r;
        r.nxt = s.nxt + widx_t'(1);
        r.on  = s.on && !is_last_word(s.nxt);
        return r;
    endfunction

endpackage

// File: rtl/qdr_phase.sv
module qdr_phase
    import qdr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    output logic k_now
);

    phase_e ph;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph <= PH_K;
        end else begin
            ph <= (ph == PH_K) ? PH_KB : PH_K;
        end
    end

    assign k_now = (ph == PH_K);

endmodule

// File: rtl/qdr_wr_ctrl.sv
module qdr_wr_ctrl
    import qdr_pkg::*;
#(
    parameter int unsigned AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          k_now,
    input  logic          wr_n,
    input  logic [AW-1:0] addr,
    output logic          we,
    output logic [AW-1:0] wa,
    output widx_t         widx
);

    // Command stage: accepted on a K edge, waits one full period
    logic          pend_v;
    logic [AW-1:0] pend_a;
    // Data stage: address of the burst whose words are arriving
    seq_t          ws;
    logic [AW-1:0] ws_a;
    logic          accept;

    assign accept = k_now && !wr_n && !pend_v;

    always_comb begin
        we   = 1'b0;
        wa   = ws_a;
        widx = ws.nxt;
        if (k_now && pend_v) begin
            we   = 1'b1;
            wa   = pend_a;
            widx = '0;
        end else if (ws.on) begin
            we = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v <= 1'b0;
            pend_a <= '0;
            ws     <= '0;
            ws_a   <= '0;
        end else begin
            if (k_now) begin
                pend_v <= accept;
                if (accept) begin
                    pend_a <= addr;
                end
            end
            if (k_now && pend_v) begin
                ws_a   <= pend_a;
                ws.on  <= 1'b1;
                ws.nxt <= widx_t'(1);
            end else if (ws.on) begin
                ws <= seq_advance(ws);
            end
        end
    end

    // R5
    wr_word0_on_k_chk: assert property (@(posedge clk) disable iff (rst)
        (we && widx == '0) |-> k_now);

    // R5
    wr_last_on_kb_chk: assert property (@(posedge clk) disable iff (rst)
        (we && is_last_word(widx)) |-> !k_now);

    // R6
    wr_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        accept |-> !($past(accept, 2) && !$past(rst, 2)));

endmodule

// File: rtl/qdr_rd_ctrl.sv
module qdr_rd_ctrl
    import qdr_pkg::*;
#(
    parameter int unsigned DW = 18
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          k_now,
    input  logic                          rd_n,
    input  logic [BURST_LEN-1:0][DW-1:0]  rdata,
    output logic [DW-1:0]                 q,
    output logic                          q_vld,
    output logic                          echo
);

    logic                         rpend;
    logic [BURST_LEN-1:0][DW-1:0] snap;
    logic [BURST_LEN-1:0][DW-1:0] sbuf;
    seq_t                         rs;
    logic                         acc;

    assign acc = k_now && !rd_n && !rpend;

    // Copy of the whole burst taken at the command edge
    always_ff @(posedge clk) begin
        if (k_now && acc) begin
            snap <= rdata;
        end
        if (k_now && rpend) begin
            sbuf <= snap;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rpend <= 1'b0;
            rs    <= '0;
            q     <= '0;
            q_vld <= 1'b0;
            echo  <= 1'b0;
        end else begin
            if (k_now) begin
                rpend <= acc;
            end
            q_vld <= rs.on;
            q     <= rs.on ? sbuf[rs.nxt] : '0;
            echo  <= !k_now;
            if (rs.on) begin
                rs <= seq_advance(rs);
            end
            if (k_now && rpend) begin
                rs.on  <= 1'b1;
                rs.nxt <= '0;
            end
        end
    end

    // R2
    rd_first_on_kb_chk: assert property (@(posedge clk) disable iff (rst)
        (rs.on && rs.nxt == '0) |-> !k_now);

    // R4
    rd_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        acc |-> !($past(acc, 2) && !$past(rst, 2)));

endmodule

// File: rtl/qdr_array.sv
module qdr_array
    import qdr_pkg::*;
#(
    parameter int unsigned DW = 18,
    parameter int unsigned AW = 6
) (
    input  logic                          clk,
    input  logic                          we,
    input  logic [AW-1:0]                 wa,
    input  widx_t                         widx,
    input  logic [DW-1:0]                 wd,
    input  logic [DW/LANE_W-1:0]          bw_n,
    input  logic [AW-1:0]                 ra,
    output logic [BURST_LEN-1:0][DW-1:0]  rdata
);

    localparam int unsigned LANES  = DW / LANE_W;
    localparam int unsigned NBURST = 1 << AW;

    // One bank per word offset so the whole burst reads at once
    for (genvar w = 0; w < BURST_LEN; w++) begin : g_bank
        logic [DW-1:0] bank [NBURST];

        always_ff @(posedge clk) begin
            if (we && widx == widx_t'(w)) begin
                for (int l = 0; l < LANES; l++) begin
                    if (!bw_n[l]) begin
                        bank[wa][l*LANE_W +: LANE_W] <= wd[l*LANE_W +: LANE_W];
                    end
                end
            end
        end

        assign rdata[w] = bank[ra];
    end

endmodule

// File: rtl/qdr_burst_sram.sv
module qdr_burst_sram
    import qdr_pkg::*;
#(
    parameter int unsigned DW = 18,
    parameter int unsigned AW = 6
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   rd_n,
    input  logic                   wr_n,
    input  logic [AW-1:0]          addr,
    input  logic [DW-1:0]          d,
    input  logic [DW/LANE_W-1:0]   bw_n,
    output logic [DW-1:0]          q,
    output logic                   q_vld,
    output logic                   echo_o,
    output logic                   k_edge_o
);

    logic                         k_now;
    logic                         we;
    logic [AW-1:0]                wa;
    widx_t                        widx;
    logic [BURST_LEN-1:0][DW-1:0] rdata;

    qdr_phase u_phase (
        .clk   (clk),
        .rst   (rst),
        .k_now (k_now)
    );

    qdr_wr_ctrl #(.AW(AW)) u_wr (
        .clk   (clk),
        .rst   (rst),
        .k_now (k_now),
        .wr_n  (wr_n),
        .addr  (addr),
        .we    (we),
        .wa    (wa),
        .widx  (widx)
    );

    qdr_array #(.DW(DW), .AW(AW)) u_mem (
        .clk   (clk),
        .we    (we),
        .wa    (wa),
        .widx  (widx),
        .wd    (d),
        .bw_n  (bw_n),
        .ra    (addr),
        .rdata (rdata)
    );

    qdr_rd_ctrl #(.DW(DW)) u_rd (
        .clk   (clk),
        .rst   (rst),
        .k_now (k_now),
        .rd_n  (rd_n),
        .rdata (rdata),
        .q     (q),
        .q_vld (q_vld),
        .echo  (echo_o)
    );

    assign k_edge_o = k_now;

    // R9
    echo_with_word0_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(q_vld) |-> echo_o);

    // R1
    burst_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(q_vld) |-> ($past(q_vld, 2) && $past(q_vld, 3) && $past(q_vld, 4)));

    // R11
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !q_vld |-> (q == '0));

endmodule

// File: tb/sim_qdr_burst_sram.sv
module sim_qdr_burst_sram;

    localparam int CLK_P = 10;
    localparam int DW    = 18;
    localparam int AW    = 6;
    localparam int LN    = DW / 9;

    logic          clk  = 1'b0;
    logic          rst  = 1'b1;
    logic          rd_n = 1'b1;
    logic          wr_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] d    = '0;
    logic [LN-1:0] bw_n = '1;
    logic [DW-1:0] q;
    logic          q_vld;
    logic          echo_o;
    logic          k_edge_o;

    qdr_burst_sram #(.DW(DW), .AW(AW)) u0 (
        .clk      (clk),
        .rst      (rst),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .addr     (addr),
        .d        (d),
        .bw_n     (bw_n),
        .q        (q),
        .q_vld    (q_vld),
        .echo_o   (echo_o),
        .k_edge_o (k_edge_o)
    );

    always #(CLK_P/2) clk = ~clk;

    int errors = 0;
    int checks = 0;
    int ecount = 0;
    string cur_req = "R1";

    logic [DW-1:0] ref_mem [64][4];
    bit            sched_v [64];
    logic [DW-1:0] sched_d [64];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One clk edge. rexp: this read is expected to be accepted.
    // wa >= 0: word wi of burst wa is expected to be taken on this edge.
    task automatic tick(input logic rdn, input logic wrn, input logic [AW-1:0] a,
                        input logic [DW-1:0] dat, input logic [LN-1:0] bw,
                        input bit rexp, input int wa, input int wi);
        logic was_k;
        int   slot;
        was_k = k_edge_o;
        rd_n = rdn; wr_n = wrn; addr = a; d = dat; bw_n = bw;
        if (rexp) begin
            for (int i = 0; i < 4; i++) begin
                slot = (ecount + 4 + i) % 64;
                sched_v[slot] = 1'b1;
                sched_d[slot] = ref_mem[a][i];
            end
        end
        if (wa >= 0) begin
            for (int l = 0; l < LN; l++) begin
                if (!bw[l]) ref_mem[wa][wi][l*9 +: 9] = dat[l*9 +: 9];
            end
        end
        @(posedge clk);
        ecount++;
        @(negedge clk);
        slot = ecount % 64;
        if (sched_v[slot]) begin
            chk(q_vld === 1'b1 && q === sched_d[slot], cur_req, "read word",
                {13'd0, q_vld, q}, {13'd0, 1'b1, sched_d[slot]});
            chk(echo_o === !was_k, "R9", "echo", {31'd0, echo_o}, {31'd0, !was_k});
            sched_v[slot] = 1'b0;
        end else begin
            chk(q_vld === 1'b0 && q === '0, cur_req, "idle output",
                {13'd0, q_vld, q}, 32'd0);
        end
        chk(k_edge_o === !was_k, "R10", "phase", {31'd0, k_edge_o}, {31'd0, !was_k});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(1'b1, 1'b1, '0, '0, '1, 1'b0, -1, 0);
    endtask

    // Idle edge that would corrupt the array if data were taken on it
    task automatic junk(input int n);
        for (int i = 0; i < n; i++) tick(1'b1, 1'b1, '0, 18'h3FFFF, '0, 1'b0, -1, 0);
    endtask

    task automatic align();
        if (!k_edge_o) idle(1);
    endtask

    task automatic wr_burst(input logic [AW-1:0] a, input logic [DW-1:0] base,
                            input logic [LN-1:0] bw);
        align();
        tick(1'b1, 1'b0, a, 18'h2AAAA, '0, 1'b0, -1, 0);
        tick(1'b1, 1'b1, '0, 18'h15555, '0, 1'b0, -1, 0);
        for (int i = 0; i < 4; i++)
            tick(1'b1, 1'b1, '0, base + DW'(i), bw, 1'b0, a, i);
        junk(2);
    endtask

    task automatic rd_burst(input logic [AW-1:0] a);
        align();
        tick(1'b0, 1'b1, a, '0, '1, 1'b1, -1, 0);
        idle(8);
    endtask

    task automatic t_reset();
        chk(q_vld === 1'b0, "R11", "reset valid", {31'd0, q_vld}, 32'd0);
        chk(q === '0, "R11", "reset data", {14'd0, q}, 32'd0);
        chk(k_edge_o === 1'b1, "R10", "reset phase", {31'd0, k_edge_o}, 32'd1);
    endtask

    task automatic t_basic();
        cur_req = "R1";
        wr_burst(6'd5, 18'h01230, '0);
        wr_burst(6'd0, 18'h10000, '0);
        wr_burst(6'd63, 18'h3F000, '0);
        rd_burst(6'd5);
        rd_burst(6'd0);
        cur_req = "R5";
        rd_burst(6'd63);
    endtask

    task automatic t_b2b_read();
        cur_req = "R2";
        wr_burst(6'd1, 18'h00110, '0);
        wr_burst(6'd2, 18'h00220, '0);
        align();
        tick(1'b0, 1'b1, 6'd1, '0, '1, 1'b1, -1, 0);
        idle(3);
        tick(1'b0, 1'b1, 6'd2, '0, '1, 1'b1, -1, 0);
        idle(3);
        tick(1'b0, 1'b1, 6'd5, '0, '1, 1'b1, -1, 0);
        idle(8);
    endtask

    task automatic t_noop();
        cur_req = "R3";
        align();
        tick(1'b0, 1'b1, 6'd1, '0, '1, 1'b1, -1, 0);
        tick(1'b0, 1'b0, 6'd2, 18'h3FFFF, '0, 1'b0, -1, 0); // K# edge: ignored
        idle(1);
        tick(1'b0, 1'b0, 6'd2, 18'h3FFFF, '0, 1'b0, -1, 0); // K# edge: ignored
        junk(8);
        rd_burst(6'd2);
    endtask

    task automatic t_rd_ignore();
        cur_req = "R4";
        align();
        tick(1'b0, 1'b1, 6'd5, '0, '1, 1'b1, -1, 0);
        idle(1);
        tick(1'b0, 1'b1, 6'd1, '0, '1, 1'b0, -1, 0); // ignored
        idle(10);
    endtask

    task automatic t_wr_ignore();
        cur_req = "R6";
        wr_burst(6'd7, 18'h07070, '0);
        wr_burst(6'd8, 18'h08080, '0);
        align();
        tick(1'b1, 1'b0, 6'd7, '0, '1, 1'b0, -1, 0);
        tick(1'b1, 1'b1, '0, 18'h3FFFF, '0, 1'b0, -1, 0);
        tick(1'b1, 1'b0, 6'd8, 18'h0A000, '0, 1'b0, 7, 0); // strobe ignored
        tick(1'b1, 1'b1, '0, 18'h0A001, '0, 1'b0, 7, 1);
        tick(1'b1, 1'b1, '0, 18'h0A002, '0, 1'b0, 7, 2);
        tick(1'b1, 1'b1, '0, 18'h0A003, '0, 1'b0, 7, 3);
        junk(4);
        rd_burst(6'd8);
        rd_burst(6'd7);
    endtask

    task automatic t_b2b_write();
        cur_req = "R5";
        align();
        tick(1'b1, 1'b0, 6'd10, '0, '1, 1'b0, -1, 0);
        tick(1'b1, 1'b1, '0, 18'h3FFFF, '0, 1'b0, -1, 0);
        tick(1'b1, 1'b1, '0, 18'h0B000, '0, 1'b0, 10, 0);
        tick(1'b1, 1'b1, '0, 18'h0B001, '0, 1'b0, 10, 1);
        tick(1'b1, 1'b0, 6'd11, 18'h0B002, '0, 1'b0, 10, 2);
        tick(1'b1, 1'b1, '0, 18'h0B003, '0, 1'b0, 10, 3);
        for (int i = 0; i < 4; i++)
            tick(1'b1, 1'b1, '0, 18'h0C000 + DW'(i), '0, 1'b0, 11, i);
        junk(2);
        rd_burst(6'd10);
        rd_burst(6'd11);
    endtask

    task automatic t_bytes();
        cur_req = "R7";
        wr_burst(6'd9, 18'h12345, '0);
        wr_burst(6'd9, 18'h3FE00, 2'b01); // only lane 1 stored
        wr_burst(6'd9, 18'h000A0, 2'b10); // only lane 0 stored
        wr_burst(6'd9, 18'h3FFFF, 2'b11); // nothing stored
        rd_burst(6'd9);
    endtask

    task automatic t_overlap();
        cur_req = "R8";
        wr_burst(6'd12, 18'h01200, '0);
        wr_burst(6'd13, 18'h01300, '0);
        align();
        tick(1'b0, 1'b0, 6'd12, '0, '1, 1'b1, -1, 0); // read and write same edge
        tick(1'b1, 1'b1, '0, 18'h3FFFF, '0, 1'b0, -1, 0);
        for (int i = 0; i < 4; i++)
            tick(1'b1, 1'b1, '0, 18'h21200 + DW'(i), '0, 1'b0, 12, i);
        idle(4);
        rd_burst(6'd12);
        align();
        tick(1'b1, 1'b0, 6'd13, '0, '1, 1'b0, -1, 0);
        tick(1'b1, 1'b1, '0, 18'h3FFFF, '0, 1'b0, -1, 0);
        tick(1'b0, 1'b1, 6'd13, 18'h21300, '0, 1'b1, 13, 0); // read at word 0 edge
        for (int i = 1; i < 4; i++)
            tick(1'b1, 1'b1, '0, 18'h21300 + DW'(i), '0, 1'b0, 13, i);
        idle(6);
        rd_burst(6'd13);
    endtask

    task automatic t_reset_mid();
        cur_req = "R11";
        wr_burst(6'd20, 18'h02000, '0);
        align();
        tick(1'b0, 1'b0, 6'd20, '0, '1, 1'b0, -1, 0);
        rd_n = 1'b1; wr_n = 1'b1;
        rst  = 1'b1;
        repeat (2) @(negedge clk);
        chk(q_vld === 1'b0, "R11", "valid in reset", {31'd0, q_vld}, 32'd0);
        rst = 1'b0;
        ecount = 0;
        for (int i = 0; i < 64; i++) sched_v[i] = 1'b0;
        junk(8);
        rd_burst(6'd20);
    endtask

    initial begin
        #(CLK_P * 50000);
        errors++;
        checks++;
        $display("FAIL R2 watchdog: actual hung expected done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) sched_v[i] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst = 1'b0;
        ecount = 0;
        t_basic();
        t_b2b_read();
        t_noop();
        t_rd_ignore();
        t_wr_ignore();
        t_b2b_write();
        t_bytes();
        t_overlap();
        t_reset_mid();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule